// File: doc/BRIEF.md
# Low-Order Interleaved Burst Read Controller

This block sits in front of 2^K independent memory banks. Each bank has its own address register, its own data register and a fixed access time of L cycles. The lowest K bits of a word address pick the bank and the upper bits pick the row inside it. Consecutive words therefore live in consecutive banks. A burst read names a start address and a word count. The controller starts one bank access per cycle, walking through successive banks, so that several banks work in parallel. It hands the words back in ascending address order with a valid strobe and a last-word flag.

A single-word write port fills the banks. It is honoured only while no burst is in flight. Only one burst is open at a time: the request side is ready again in the same cycle that the last word of the current burst appears on the output.

Top module: `ilv_read_ctrl`

## Requirements
- R1: A word written to address `a` is stored in bank `a[K-1:0]` at row `a[AW-1:K]`, and a later burst that covers `a` returns exactly that word.
- R2: A burst of `n` words from address `s` returns the words at `s, s+1, ... s+n-1`, in that order. Addresses wrap modulo 2^AW.
- R3: `outLast` is high together with `outValid` on the n-th word of a burst and is low on every other cycle.
- R4: A request is taken when `reqValid` and `reqReady` are both high. `reqReady` is low from the edge that takes a request until the cycle in which that burst's last word is valid. A request raised while `reqReady` is low is ignored and produces no words.
- R5: A request whose `reqLen` is 0 or greater than 16 is ignored: no words are returned and `reqReady` stays high.
- R6: `wrEn` is ignored while a burst is open. A word written at that time is not stored, and the old contents are read back.
- R7: A bank gets at most one new access per cycle. It is never started again until its previous access has finished (L cycles) and its word has been handed out. With the defaults, the fifth word of a burst that starts at bank 0 appears no earlier than 10 cycles after the request is taken.
- R8: Accesses overlap across banks. With the defaults, the first word of a burst is valid 6 cycles after the edge that takes the request (L+2). A 4-word burst starting at a bank-0 address delivers its words on 4 consecutive cycles.
- R9: After reset, `reqReady` is 1, and `outValid` and `outLast` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Burst request present |
| reqAddr | input | AW (6) | Burst start word address |
| reqLen | input | LW (5) | Burst length in words, 1 to 16 |
| reqReady | output | 1 | Controller can take a request |
| wrEn | input | 1 | Write one word (idle only) |
| wrAddr | input | AW (6) | Write word address |
| wrData | input | W (16) | Write data |
| outValid | output | 1 | Output word valid |
| outLast | output | 1 | Final word of the burst |
| outData | output | W (16) | Returned word |

## Verification
The hardest situation to reach is a burst that wraps back onto a bank whose earlier access is still running or whose word has not been handed out yet. Only that case exercises the issue stall. The bench gets there with bursts longer than the bank count, including 16-word bursts and one that crosses the top of the address space. It then checks the order and arrival time of the fifth word. Requests and writes are also injected in the middle of an open burst, and a follow-up read confirms that they left no trace.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic issue;    // start an access in issue bank
    logic pop;      // hand out the word of the pop bank
    logic popLast;  // that word ends the burst
    logic write;    // store the write-port word
  } ctlStrobes_t;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int M = 4,
  parameter int W = 16,
  parameter int L = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wrEn,
  input  logic [M-1:0] wrRow,
  input  logic [W-1:0] wrData,
  input  logic         start,
  input  logic [M-1:0] row,
  input  logic         pop,
  output logic         idle,
  output logic         full,
  output logic [W-1:0] data
);
  localparam int DEPTH = 1 << M;
  localparam int CW = $clog2(L + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [M-1:0]  addrReg;
  logic [W-1:0]  dataReg;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrRow] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      dataReg <= '0;
      cnt     <= '0;
      full    <= 1'b0;
    end else begin
      if (start) begin
        addrReg <= row;
        cnt     <= CW'(L);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
      if (cnt == CW'(1)) begin
        dataReg <= mem[addrReg];
        full    <= 1'b1;
      end else if (pop) begin
        full <= 1'b0;
      end
    end
  end

  assign idle = (cnt == '0) && !full;
  assign data = dataReg;
endmodule

// File: rtl/ilv_datapath.sv
module ilv_datapath
  import ilv_pkg::*;
#(
  parameter int K = 2,
  parameter int M = 4,
  parameter int W = 16,
  parameter int L = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobes_t      stb,
  input  logic [K-1:0]     issueBank,
  input  logic [M-1:0]     issueRow,
  input  logic [K-1:0]     popBank,
  input  logic [K+M-1:0]   wrAddr,
  input  logic [W-1:0]     wrData,
  output logic [(1<<K)-1:0] bankIdle,
  output logic [(1<<K)-1:0] bankFull,
  output logic             outValid,
  output logic             outLast,
  output logic [W-1:0]     outData
);
  localparam int N = 1 << K;

  logic [W-1:0] bankData [N];

  for (genvar i = 0; i < N; i++) begin : g_bank
    ilv_bank #(.M(M), .W(W), .L(L)) bank (
      .clk    (clk),
      .rst    (rst),
      .wrEn   (stb.write && (wrAddr[K-1:0] == K'(i))),
      .wrRow  (wrAddr[K+M-1:K]),
      .wrData (wrData),
      .start  (stb.issue && (issueBank == K'(i))),
      .row    (issueRow),
      .pop    (stb.pop && (popBank == K'(i))),
      .idle   (bankIdle[i]),
      .full   (bankFull[i]),
      .data   (bankData[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= stb.pop;
      outLast  <= stb.popLast;
      if (stb.pop) outData <= bankData[popBank];
    end
  end
endmodule

// File: rtl/ilv_control.sv
module ilv_control
  import ilv_pkg::*;
#(
  parameter int K = 2,
  parameter int M = 4,
  parameter int MAXLEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [K+M-1:0]    reqAddr,
  input  logic [$clog2(MAXLEN+1)-1:0] reqLen,
  input  logic              wrEn,
  input  logic [(1<<K)-1:0] bankIdle,
  input  logic [(1<<K)-1:0] bankFull,
  output ctlStrobes_t       stb,
  output logic [K-1:0]      issueBank,
  output logic [M-1:0]      issueRow,
  output logic [K-1:0]      popBank,
  output logic              reqReady
);
  localparam int AW = K + M;
  localparam int LW = $clog2(MAXLEN + 1);

  logic          active;
  logic [AW-1:0] issAddr;
  logic [LW-1:0] issLeft;
  logic [K-1:0]  rdBank;
  logic [LW-1:0] rdLeft;
  logic          lenOk;

  assign lenOk     = (reqLen != '0) && (reqLen <= LW'(MAXLEN));
  assign reqReady  = !active;
  assign issueBank = issAddr[K-1:0];
  assign issueRow  = issAddr[AW-1:K];
  assign popBank   = rdBank;

  always_comb begin
    stb.issue   = active && (issLeft != '0) && bankIdle[issueBank];
    stb.pop     = active && (rdLeft != '0) && bankFull[rdBank];
    stb.popLast = stb.pop && (rdLeft == LW'(1));
    stb.write   = wrEn && !active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      issAddr <= '0;
      issLeft <= '0;
      rdBank  <= '0;
      rdLeft  <= '0;
    end else if (!active) begin
      if (reqValid && lenOk) begin
        active  <= 1'b1;
        issAddr <= reqAddr;
        issLeft <= reqLen;
        rdBank  <= reqAddr[K-1:0];
        rdLeft  <= reqLen;
      end
    end else begin
      if (stb.issue) begin
        issAddr <= issAddr + 1'b1;
        issLeft <= issLeft - 1'b1;
      end
      if (stb.pop) begin
        rdBank <= rdBank + 1'b1;
        rdLeft <= rdLeft - 1'b1;
      end
      if (stb.popLast) active <= 1'b0;
    end
  end
endmodule

// File: rtl/ilv_read_ctrl.sv
module ilv_read_ctrl
  import ilv_pkg::*;
#(
  parameter int K = 2,
  parameter int M = 4,
  parameter int W = 16,
  parameter int L = 4,
  parameter int MAXLEN = 16,
  localparam int AW = K + M,
  localparam int LW = $clog2(MAXLEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic [LW-1:0] reqLen,
  output logic          reqReady,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData,
  output logic          outValid,
  output logic          outLast,
  output logic [W-1:0]  outData
);
  localparam int N = 1 << K;

  ctlStrobes_t  stb;
  logic [K-1:0] issueBank;
  logic [M-1:0] issueRow;
  logic [K-1:0] popBank;
  logic [N-1:0] bankIdle;
  logic [N-1:0] bankFull;

  ilv_control #(.K(K), .M(M), .MAXLEN(MAXLEN)) ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .wrEn(wrEn), .bankIdle(bankIdle), .bankFull(bankFull),
    .stb(stb), .issueBank(issueBank), .issueRow(issueRow),
    .popBank(popBank), .reqReady(reqReady)
  );

  ilv_datapath #(.K(K), .M(M), .W(W), .L(L)) dp (
    .clk(clk), .rst(rst), .stb(stb), .issueBank(issueBank),
    .issueRow(issueRow), .popBank(popBank), .wrAddr(wrAddr),
    .wrData(wrData), .bankIdle(bankIdle), .bankFull(bankFull),
    .outValid(outValid), .outLast(outLast), .outData(outData)
  );
endmodule

// File: rtl/ilv_read_ctrl_chk.sv
module ilv_read_ctrl_chk
  import ilv_pkg::*;
#(
  parameter int K = 2,
  parameter int L = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         reqReady,
  input logic         outValid,
  input logic         outLast,
  input ctlStrobes_t  stb,
  input logic [K-1:0] issueBank
);
  localparam int N = 1 << K;
  localparam int CW = $clog2(L + 1);

  // R3
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    outLast |-> outValid);

  // R4
  busy_while_streaming_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outLast) |-> !reqReady);

  // R4
  ready_returns_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(reqReady) |-> outLast);

  // independent per-bank shadow of access time
  for (genvar i = 0; i < N; i++) begin : g_shadow
    logic [CW-1:0] shadow;
    always_ff @(posedge clk) begin
      if (rst) shadow <= '0;
      else if (stb.issue && issueBank == K'(i)) shadow <= CW'(L);
      else if (shadow != '0) shadow <= shadow - 1'b1;
    end
    // R7
    no_busy_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (stb.issue && issueBank == K'(i)) |-> (shadow == '0));
  end
endmodule

bind ilv_read_ctrl ilv_read_ctrl_chk #(.K(K), .L(L)) chk (
  .clk(clk), .rst(rst), .reqReady(reqReady), .outValid(outValid),
  .outLast(outLast), .stb(stb), .issueBank(issueBank)
);

// File: tb/ilv_read_ctrl_test.sv
module ilv_read_ctrl_test;
  localparam int AW = 6;
  localparam int LW = 5;
  localparam int W  = 16;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [LW-1:0] reqLen = '0;
  logic          reqReady;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [W-1:0]  wrData = '0;
  logic          outValid, outLast;
  logic [W-1:0]  outData;

  int nChk = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  ilv_read_ctrl uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqLen(reqLen), .reqReady(reqReady), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .outValid(outValid), .outLast(outLast), .outData(outData)
  );

  // start address (6 bits), length (5 bits)
  localparam logic [10:0] VEC [0:7] = '{
    {6'd0, 5'd1}, {6'd0, 5'd4}, {6'd1, 5'd5}, {6'd3, 5'd16},
    {6'd62, 5'd4}, {6'd5, 5'd16}, {6'd2, 5'd7}, {6'd63, 5'd1}
  };

  function automatic logic [W-1:0] pat(input int a);
    return W'((a * 311) ^ 23100);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeWord(input int a, input logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = AW'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic quiet(input string tag);
    bit seen = 1'b0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (outValid) seen = 1'b1;
    end
    check(!seen, {tag, " no stray words"}, int'(seen), 0);
    check(reqReady, {tag, " ready after"}, int'(reqReady), 1);
  endtask

  task automatic runBurst(input int a, input int n, input bit injReq, input bit injWr,
                          output int firstK, output int k4, output int lastK);
    int got = 0;
    int k = 0;
    firstK = -1; k4 = -1; lastK = -1;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqAddr = AW'(a); reqLen = LW'(n);
    @(negedge clk);
    reqValid = 1'b0;
    while (got < n && k < 300) begin
      if (outValid) begin
        // R1 R2: words in ascending wrapped order
        check(outData == pat((a + got) % NW), "R2 burst word", outData, pat((a + got) % NW));
        // R3: last flag only on final word
        check(outLast == (got == n - 1), "R3 last flag", outLast, (got == n - 1));
        // R4: ready low until last word
        check(reqReady == (got == n - 1), "R4 ready", reqReady, (got == n - 1));
        if (got == 0) firstK = k;
        if (got == 4) k4 = k;
        lastK = k;
        got++;
      end
      if (injReq && k == 2) begin
        reqValid = 1'b1; reqAddr = 6'd3; reqLen = 5'd2;
      end
      if (injWr && k == 2) begin
        wrEn = 1'b1; wrAddr = AW'((a + n - 1) % NW); wrData = 16'hDEAD;
      end
      if (k == 3) begin
        reqValid = 1'b0; wrEn = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    reqValid = 1'b0; wrEn = 1'b0;
    check(got == n, "R2 word count", got, n);
  endtask

  initial begin
    #(200000 * 10);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int f, q, l;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(reqReady == 1'b1, "R9 reset ready", reqReady, 1);
    check(outValid == 1'b0, "R9 reset valid", outValid, 0);
    check(outLast == 1'b0, "R9 reset last", outLast, 0);

    // R1 fill every bank through the write port
    for (int a = 0; a < NW; a++) writeWord(a, pat(a));

    // table walk: R1 R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      runBurst(int'(VEC[i][10:5]), int'(VEC[i][4:0]), 1'b0, 1'b0, f, q, l);
    end

    // R8 overlap: aligned 4-word burst
    runBurst(4, 4, 1'b0, 1'b0, f, q, l);
    check(f == 6, "R8 first word latency", f, 6);
    check(l - f == 3, "R8 back-to-back words", l - f, 3);

    // R7 wrap onto bank 0 cannot restart early
    runBurst(8, 5, 1'b0, 1'b0, f, q, l);
    check(q >= 10, "R7 fifth word not before bank frees", q, 10);

    // R5 bad lengths ignored
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 6'd0; reqLen = 5'd0;
    @(negedge clk);
    reqValid = 1'b0;
    quiet("R5 len0");
    reqValid = 1'b1; reqAddr = 6'd0; reqLen = 5'd17;
    @(negedge clk);
    reqValid = 1'b0;
    quiet("R5 len17");

    // R4 request while busy ignored
    runBurst(40, 8, 1'b1, 1'b0, f, q, l);
    quiet("R4 busy request");

    // R6 write while busy ignored
    runBurst(20, 6, 1'b0, 1'b1, f, q, l);
    runBurst(25, 1, 1'b0, 1'b0, f, q, l);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule